// File: doc/BRIEF.md
# Programmable field and vertical sync timing adjuster

This block sits behind a video sync extractor for 625-line video and reshapes two vertical timing signals. The extractor supplies a line strobe and, qualified by that strobe, three nominal events: the field change, the start of vertical sync and the end of vertical sync. It also supplies a level that tells whether the field in progress is odd. The block produces a field level and a vertical sync level. Each comes out twice: once for the FIELD and VS pins and once as the F and V bits of an embedded timing code. The two copies of each always agree.

Software sets, per event, a five-bit line offset and a direction bit. With the direction bit clear, the adjusted transition comes that many lines after the nominal event. With it set, the transition comes that many lines before the next nominal event. Two further bits add one line of delay to the field transition, one for odd fields and one for even fields. The settings are taken into a shadow copy only on a nominal field event. A change written mid-field therefore cannot cut short or repeat a transition that is already scheduled. Advance timing counts lines from the previous nominal event against a programmable lines-per-field value.

Top module: `fvt_field_vsync_adj`

## Requirements
- R1: While reset is high and on the first clock after it, `field_o`, `f_bit_o`, `vs_o` and `v_bit_o` are 0. The shadow settings reset to: field offset 3, field advance 1, odd extra 0, even extra 1, vsync end offset 20, vsync end advance 0.
- R2: The field shift is computed as S = (advance ? -offset : offset) + extra. When S >= 0, `field_o` toggles S line strobes after the nominal field event. When S = 0, it toggles on the clock edge that ends the event's own strobe cycle.
- R3: The extra line is the odd-field bit when `odd_fld`=1 and the even-field bit when `odd_fld`=0. For a delay, `odd_fld` is sampled with the nominal field event and describes the field that the event ends. For an advance, `odd_fld` describes the field in progress.
- R4: When S < 0, `field_o` toggles on the strobe whose count of lines since the previous nominal field event equals lines_per_field + S. No advance toggle occurs before the first nominal field event.
- R5: A strobe carrying `vbeg_evt` sets `vs_o`. If an adjusted vsync end falls on the same strobe, the set wins.
- R6: `vs_o` clears at the adjusted vsync end: `v_ofs` strobes after the nominal end event when `v_adv`=0 or `v_ofs`=0. Otherwise it clears `v_ofs` lines before the next nominal end event, counted from the previous nominal end event; this needs one earlier nominal end event.
- R7: All `cfg_*` inputs are captured only on a strobe carrying `fld_evt`. Changes at other times have no effect until that capture. A delay decided at an event uses the settings in force before the capture.
- R8: `f_bit_o` always equals `field_o`, and `v_bit_o` always equals `vs_o`.
- R9: The event inputs are ignored on cycles where `line_stb`=0, and the outputs change only on the clock edge after a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle strobe per video line; qualifies the event inputs |
| fld_evt | input | 1 | Nominal field change on this line |
| vbeg_evt | input | 1 | Nominal vertical sync start on this line |
| vend_evt | input | 1 | Nominal vertical sync end on this line |
| odd_fld | input | 1 | 1 while the field in progress is odd |
| cfg_f_ofs | input | 5 | Field transition line offset |
| cfg_f_adv | input | 1 | 1 = advance field transition, 0 = delay |
| cfg_dly_odd | input | 1 | Extra line of field delay on odd fields |
| cfg_dly_even | input | 1 | Extra line of field delay on even fields |
| cfg_v_ofs | input | 5 | Vertical sync end line offset |
| cfg_v_adv | input | 1 | 1 = advance vsync end, 0 = delay |
| cfg_lpf | input | 10 | Lines per field, reference for advance mode |
| field_o | output | 1 | FIELD pin level |
| f_bit_o | output | 1 | F bit of the embedded timing code |
| vs_o | output | 1 | VS pin level |
| v_bit_o | output | 1 | V bit of the embedded timing code |

## Verification
Three things can land on one strobe: the start of vertical sync, an advanced vsync end, and an adjusted field toggle. A directed field sets the vsync end advance to exactly the distance between the nominal start and end, so the advanced end falls on the start strobe. The bench expects the sync to stay high because the start wins. The same and later random fields let field toggles coincide with vsync edges, and each output is judged line by line against targets that bench functions compute from the shadowed settings. Settings are rewritten mid-field while delays are pending, to show that they act only from the next field event.

// File: rtl/fvt_pkg.sv
package fvt_pkg;
  localparam int OFS_W  = 5;
  localparam int LINE_W = 10;

  typedef struct packed {
    logic [OFS_W-1:0]  f_ofs;
    logic              f_adv;
    logic              dly_odd;
    logic              dly_even;
    logic [OFS_W-1:0]  v_ofs;
    logic              v_adv;
    logic [LINE_W-1:0] lpf;
  } fvt_cfg_t;

  localparam fvt_cfg_t CFG_RESET = '{
    f_ofs:    OFS_W'(3),
    f_adv:    1'b1,
    dly_odd:  1'b0,
    dly_even: 1'b1,
    v_ofs:    OFS_W'(20),
    v_adv:    1'b0,
    lpf:      LINE_W'(312)
  };
endpackage

// File: rtl/fvt_cfg_shadow.sv
module fvt_cfg_shadow
  import fvt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  fvt_cfg_t cfg_in,
  output fvt_cfg_t cfg_q
);
  // Settings move into the working copy only at a field boundary.
  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= CFG_RESET;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/fvt_line_shifter.sv
module fvt_line_shifter #(
  parameter int OFS_W  = 5,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_stb,
  input  logic              evt,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              adv,
  input  logic              extra,
  input  logic [LINE_W-1:0] lpf,
  output logic              fire
);
  localparam int CNT_W = OFS_W + 1;
  localparam logic [LINE_W-1:0] SINCE_MAX = {LINE_W{1'b1}};

  logic [CNT_W-1:0]  cnt;
  logic              pend;
  logic [LINE_W-1:0] since;
  logic              armed;

  logic              adv_mode;
  logic [CNT_W-1:0]  dly_amt;
  logic [CNT_W-1:0]  adv_amt;
  logic [LINE_W-1:0] adv_line;
  logic              adv_hit;
  logic              dly_now;
  logic              dly_end;

  always_comb begin
    adv_mode = adv && (ofs > OFS_W'(extra));
    if (adv) dly_amt = CNT_W'(extra) - CNT_W'(ofs);
    else     dly_amt = CNT_W'(ofs) + CNT_W'(extra);
    adv_amt  = CNT_W'(ofs) - CNT_W'(extra);
    adv_line = lpf - LINE_W'(adv_amt);
    adv_hit  = armed && !evt && adv_mode && ((since + LINE_W'(1)) == adv_line);
    dly_now  = evt && !adv_mode && (dly_amt == '0);
    dly_end  = pend && (cnt == CNT_W'(1));
    fire     = line_stb && (adv_hit || dly_now || dly_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pend  <= 1'b0;
      since <= '0;
      armed <= 1'b0;
    end else if (line_stb) begin
      if (evt)                   since <= '0;
      else if (since != SINCE_MAX) since <= since + LINE_W'(1);
      if (evt) armed <= 1'b1;
      if (evt && !adv_mode && (dly_amt != '0)) begin
        cnt  <= dly_amt;
        pend <= 1'b1;
      end else if (pend) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fvt_field_vsync_adj.sv
module fvt_field_vsync_adj
  import fvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              line_stb,
  input  logic              fld_evt,
  input  logic              vbeg_evt,
  input  logic              vend_evt,
  input  logic              odd_fld,
  input  logic [OFS_W-1:0]  cfg_f_ofs,
  input  logic              cfg_f_adv,
  input  logic              cfg_dly_odd,
  input  logic              cfg_dly_even,
  input  logic [OFS_W-1:0]  cfg_v_ofs,
  input  logic              cfg_v_adv,
  input  logic [LINE_W-1:0] cfg_lpf,
  output logic              field_o,
  output logic              f_bit_o,
  output logic              vs_o,
  output logic              v_bit_o
);
  fvt_cfg_t cfg_in;
  fvt_cfg_t sh;
  logic     f_extra;
  logic     f_fire;
  logic     v_fire;
  logic     field_nx;
  logic     vs_nx;

  always_comb begin
    cfg_in.f_ofs    = cfg_f_ofs;
    cfg_in.f_adv    = cfg_f_adv;
    cfg_in.dly_odd  = cfg_dly_odd;
    cfg_in.dly_even = cfg_dly_even;
    cfg_in.v_ofs    = cfg_v_ofs;
    cfg_in.v_adv    = cfg_v_adv;
    cfg_in.lpf      = cfg_lpf;
  end

  fvt_cfg_shadow u_shadow (
    .clk    (clk),
    .rst    (rst),
    .load   (line_stb && fld_evt),
    .cfg_in (cfg_in),
    .cfg_q  (sh)
  );

  assign f_extra = odd_fld ? sh.dly_odd : sh.dly_even;

  fvt_line_shifter #(.OFS_W(OFS_W), .LINE_W(LINE_W)) u_fshift (
    .clk      (clk),
    .rst      (rst),
    .line_stb (line_stb),
    .evt      (fld_evt),
    .ofs      (sh.f_ofs),
    .adv      (sh.f_adv),
    .extra    (f_extra),
    .lpf      (sh.lpf),
    .fire     (f_fire)
  );

  fvt_line_shifter #(.OFS_W(OFS_W), .LINE_W(LINE_W)) u_vshift (
    .clk      (clk),
    .rst      (rst),
    .line_stb (line_stb),
    .evt      (vend_evt),
    .ofs      (sh.v_ofs),
    .adv      (sh.v_adv),
    .extra    (1'b0),
    .lpf      (sh.lpf),
    .fire     (v_fire)
  );

  // Sync start takes priority over an adjusted end on the same line.
  always_comb begin
    field_nx = field_o ^ f_fire;
    if (line_stb && vbeg_evt) vs_nx = 1'b1;
    else if (v_fire)          vs_nx = 1'b0;
    else                      vs_nx = vs_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      field_o <= 1'b0;
      f_bit_o <= 1'b0;
      vs_o    <= 1'b0;
      v_bit_o <= 1'b0;
    end else begin
      field_o <= field_nx;
      f_bit_o <= field_nx;
      vs_o    <= vs_nx;
      v_bit_o <= vs_nx;
    end
  end
endmodule

// File: rtl/fvt_checker.sv
module fvt_checker (
  input logic clk,
  input logic rst,
  input logic line_stb,
  input logic vbeg_evt,
  input logic field_o,
  input logic f_bit_o,
  input logic vs_o,
  input logic v_bit_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!field_o && !vs_o && !f_bit_o && !v_bit_o));

  p_vbeg_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (line_stb && vbeg_evt) |=> vs_o);

  p_vs_rise_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_o) |-> $past(line_stb && vbeg_evt));

  p_field_pair_r8: assert property (@(posedge clk) disable iff (rst)
    f_bit_o == field_o);

  p_vsync_pair_r8: assert property (@(posedge clk) disable iff (rst)
    v_bit_o == vs_o);

  p_field_on_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(line_stb) |-> $stable(field_o));

  p_vs_on_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(line_stb) |-> $stable(vs_o));
endmodule

bind fvt_field_vsync_adj fvt_checker u_fvt_checker (
  .clk      (clk),
  .rst      (rst),
  .line_stb (line_stb),
  .vbeg_evt (vbeg_evt),
  .field_o  (field_o),
  .f_bit_o  (f_bit_o),
  .vs_o     (vs_o),
  .v_bit_o  (v_bit_o)
);

// File: tb/tb_fvt_field_vsync_adj.sv
module tb_fvt_field_vsync_adj;
  import fvt_pkg::*;

  localparam int LPF    = 80;
  localparam int FIRST  = 10;
  localparam int VB_OFS = 10;
  localparam int VE_OFS = 40;
  localparam int FIELDS = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic line_stb = 0, fld_evt = 0, vbeg_evt = 0, vend_evt = 0, odd_fld = 0;
  logic [OFS_W-1:0] cfg_f_ofs = 0, cfg_v_ofs = 0;
  logic cfg_f_adv = 0, cfg_dly_odd = 0, cfg_dly_even = 0, cfg_v_adv = 0;
  logic [LINE_W-1:0] cfg_lpf = LINE_W'(LPF);
  logic field_o, f_bit_o, vs_o, v_bit_o;

  fvt_field_vsync_adj dut (.*);

  int errors = 0, checks = 0;
  bit finished = 0;

  // bench model state
  int  tfd = -1, tfa = -1, tvd = -1, tva = -1;
  bit  ef = 0, ev = 0, par = 1, armed_v = 0;
  int  s_fofs = 3, s_vofs = 20;
  bit  s_fadv = 1, s_do = 0, s_de = 1, s_vadv = 0;

  function automatic int shift_of(bit adv, int ofs, bit extra);
    return (adv ? -ofs : ofs) + int'(extra);
  endfunction

  function automatic bit extra_of(bit odd, bit d_odd, bit d_even);
    return odd ? d_odd : d_even;
  endfunction

  task automatic chk(input logic got, input bit exp, input string tag, input int line);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s line %0d: actual %0b expected %0b", tag, line, got, exp);
    end
  endtask

  task automatic set_cfg(input int k);
    case (k)
      0: begin cfg_f_adv = 0; cfg_f_ofs = 0;  cfg_dly_odd = 0; cfg_dly_even = 0; cfg_v_adv = 0; cfg_v_ofs = 0;  end
      1: begin cfg_f_adv = 0; cfg_f_ofs = 5;  cfg_dly_odd = 0; cfg_dly_even = 1; cfg_v_adv = 0; cfg_v_ofs = 7;  end
      2: begin cfg_f_adv = 1; cfg_f_ofs = 4;  cfg_dly_odd = 1; cfg_dly_even = 1; cfg_v_adv = 1; cfg_v_ofs = 30; end
      3: begin cfg_f_adv = 1; cfg_f_ofs = 1;  cfg_dly_odd = 1; cfg_dly_even = 1; cfg_v_adv = 1; cfg_v_ofs = 5;  end
      4: begin cfg_f_adv = 0; cfg_f_ofs = 31; cfg_dly_odd = 1; cfg_dly_even = 1; cfg_v_adv = 0; cfg_v_ofs = 31; end
      default: begin
        cfg_f_adv    = $urandom % 2;
        cfg_f_ofs    = OFS_W'($urandom % 32);
        cfg_dly_odd  = $urandom % 2;
        cfg_dly_even = $urandom % 2;
        cfg_v_adv    = $urandom % 2;
        cfg_v_ofs    = OFS_W'($urandom % 30);
      end
    endcase
  endtask

  task automatic do_line(input int L);
    bit fe, vb, ve;
    int s;
    logic hold_f, hold_v;
    fe = (L >= FIRST) && ((L - FIRST) % LPF == 0);
    vb = (L >= FIRST) && ((L - FIRST) % LPF == VB_OFS);
    ve = (L >= FIRST) && ((L - FIRST) % LPF == VE_OFS);
    @(negedge clk);
    line_stb = 1; fld_evt = fe; vbeg_evt = vb; vend_evt = ve; odd_fld = par;
    @(negedge clk);
    line_stb = 0; fld_evt = 0; vbeg_evt = 0; vend_evt = 0;
    if (fe) begin
      s = shift_of(s_fadv, s_fofs, extra_of(par, s_do, s_de));
      if (s >= 0) tfd = L + s;
      s_fofs = int'(cfg_f_ofs); s_fadv = cfg_f_adv; s_do = cfg_dly_odd;
      s_de = cfg_dly_even; s_vofs = int'(cfg_v_ofs); s_vadv = cfg_v_adv;
      par = ~par;
      s = shift_of(s_fadv, s_fofs, extra_of(par, s_do, s_de));
      if (s < 0) tfa = L + LPF + s;
      if (s_vadv && s_vofs > 0) begin
        if (armed_v) tva = L + VE_OFS - s_vofs;
      end else tvd = L + VE_OFS + s_vofs;
    end
    if (ve) armed_v = 1;
    if (L == tfd || L == tfa) ef = ~ef;
    if (vb) ev = 1;
    else if (L == tvd || L == tva) ev = 0;
    chk(field_o, ef, "R2 R3 R4 R7 field level", L);
    chk(vs_o, ev, "R5 R6 vsync level", L);
    chk(f_bit_o, ef, "R8 F bit", L);
    chk(v_bit_o, ev, "R8 V bit", L);
    odd_fld = par;
    if (L >= FIRST && (L - FIRST) % LPF == 20) set_cfg((L - FIRST) / LPF + 1);
    // unqualified events must change nothing
    hold_f = field_o; hold_v = vs_o;
    for (int j = 0; j < 2; j++) begin
      fld_evt = $urandom % 2; vbeg_evt = $urandom % 2; vend_evt = $urandom % 2;
      @(negedge clk);
    end
    fld_evt = 0; vbeg_evt = 0; vend_evt = 0;
    if ((L % 7) == 3) begin
      chk(field_o, hold_f, "R9 field without strobe", L);
      chk(vs_o, hold_v, "R9 vsync without strobe", L);
    end
  endtask

  initial begin
    void'($urandom(32'd4517));
    set_cfg(0);
    repeat (3) @(negedge clk);
    chk(field_o, 1'b0, "R1 reset field", -1);
    chk(vs_o, 1'b0, "R1 reset vsync", -1);
    rst = 0;
    @(negedge clk);
    chk(field_o, 1'b0, "R1 after reset field", -1);
    chk(v_bit_o, 1'b0, "R1 after reset V bit", -1);
    for (int L = 0; L < FIRST + FIELDS * LPF; L++) do_line(L);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule